// File: doc/BRIEF.md
# Power-Management Event Interrupt Unit

This block keeps a 16-bit event status register and a 16-bit event enable register for power-management events. It drives a level-sensitive system control interrupt, and it tells the periodic timer when a wake-up should be armed. Event sources pulse `evt_i` for one cycle. Each pulse latches the matching status bit. Software clears status bits by writing ones to them.

Both registers are reached through a 64-byte window in I/O space. A configuration-write port places and enables the window. The base comes from the configuration dword at byte offset 0x40, with the low six bits discarded. The window is enabled by bit 0 of the configuration byte at offset 0x80. After reset the window is disabled.

Top module: `pm_evt_irq`

## Requirements
- R1: After reset, status and enable are 0x0000, `irq_o` and `tmr_arm_o` are low, and the window is disabled.
- R2: The window base is the configuration dword at byte offset 0x40 ANDed with 0xFFC0. Only byte lanes 0 and 1 (`cfg_be_i[1:0]`) hold base bits, and a write updates only the lanes it enables.
- R3: The window is decoded only while bit 0 of the configuration byte at offset 0x80 (dword 0x80, lane 0) is 1. While the window is disabled, reads return 0xFFFF and writes have no effect.
- R4: An I/O address whose bits [15:6] differ from the base reads 0xFFFF, and a write to it has no effect.
- R5: A 1 on bit n of `evt_i` in a cycle sets status bit n at the next clock edge. Status reads at window offset 0.
- R6: A write to offset 0 clears each status bit written as 1. Bits written as 0 keep their value.
- R7: Enable reads and writes at window offset 2 and takes the full written value. Every other offset in the window reads 0x0000 and ignores writes.
- R8: `irq_o` is high exactly when (status & enable & 0x0521) is nonzero. The mask selects the timer (bit 0), global lock (bit 5), power button (bit 8) and RTC alarm (bit 10). No other bit can raise the interrupt.
- R9: `tmr_arm_o` is high exactly when enable bit 0 is 1 and status bit 0 is 0.
- R10: If an event pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration byte address (dword aligned) |
| cfg_be_i | input | 4 | Configuration byte enables |
| cfg_wdata_i | input | 32 | Configuration write data |
| io_req_i | input | 1 | I/O access strobe |
| io_we_i | input | 1 | I/O write (1) or read (0) |
| io_addr_i | input | 16 | I/O address |
| io_wdata_i | input | 16 | I/O write data |
| io_rdata_o | output | 16 | I/O read data (combinational) |
| evt_i | input | 16 | Event pulses, one per status bit |
| irq_o | output | 1 | System control interrupt level |
| tmr_arm_o | output | 1 | Timer wake-up armed |

## Verification
The assertions check the following on every cycle:
- Status bits never drop without a clearing write.
- Every event pulse lands in status.
- Enable stays stable unless it is written.
- Disabling the window stops the decode.
- Clearing enable bit 0 disarms the timer.

Only the bench scenarios can show the rest:
- The window address arithmetic, including the base mask and partial byte-lane updates.
- The all-ones reads outside the window.
- That the four masked sources raise the interrupt and the other bits do not.
- That a set wins over a clear in the same cycle.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int REG_W       = 16;
  localparam int IO_AW       = 16;
  localparam int WIN_AW      = 6;
  localparam int BIT_TMR     = 0;
  localparam int BIT_GLOCK   = 5;
  localparam int BIT_PWRBTN  = 8;
  localparam int BIT_RTC     = 10;
  localparam logic [REG_W-1:0] IRQ_MASK =
    REG_W'((1 << BIT_TMR) | (1 << BIT_GLOCK) | (1 << BIT_PWRBTN) | (1 << BIT_RTC));
  localparam logic [7:0] CFG_BASE_OFF = 8'h40;
  localparam logic [7:0] CFG_EN_OFF   = 8'h80;
  localparam logic [WIN_AW-1:0] OFF_STS = 6'd0;
  localparam logic [WIN_AW-1:0] OFF_EN  = 6'd2;
endpackage

// File: rtl/pm_win_decode.sv
module pm_win_decode
  import pm_evt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [7:0]        cfg_addr_i,
  input  logic [3:0]        cfg_be_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic [IO_AW-1:0]  io_addr_i,
  output logic              hit_o,
  output logic [WIN_AW-1:0] off_o
);
  localparam int BASE_W = IO_AW - WIN_AW;

  logic [BASE_W-1:0] base_q;
  logic              win_en_q;
  logic              base_sel, en_sel;

  assign base_sel = cfg_we_i && (cfg_addr_i[7:2] == CFG_BASE_OFF[7:2]);
  assign en_sel   = cfg_we_i && (cfg_addr_i[7:2] == CFG_EN_OFF[7:2]);

  // lane 0 contributes only bits [7:WIN_AW]; lane 1 gives [15:8]
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      win_en_q <= 1'b0;
    end else begin
      if (base_sel && cfg_be_i[0]) base_q[7-WIN_AW:0]    <= cfg_wdata_i[7:WIN_AW];
      if (base_sel && cfg_be_i[1]) base_q[BASE_W-1:8-WIN_AW] <= cfg_wdata_i[IO_AW-1:8];
      if (en_sel && cfg_be_i[0])   win_en_q <= cfg_wdata_i[0];
    end
  end

  assign hit_o = win_en_q && (io_addr_i[IO_AW-1:WIN_AW] == base_q);
  assign off_o = io_addr_i[WIN_AW-1:0];

  // R3
  win_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_sel && cfg_be_i[0] && !cfg_wdata_i[0]) |=> !hit_o);
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
  import pm_evt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] evt_i,
  input  logic             sts_wr_i,
  input  logic             en_wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] sts_o,
  output logic [REG_W-1:0] en_o
);
  logic [REG_W-1:0] sts_q, en_q, clr_mask;

  assign clr_mask = sts_wr_i ? wdata_i : '0;

  // per-bit status cells; set beats clear
  for (genvar i = 0; i < REG_W; i++) begin : g_sts
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       sts_q[i] <= 1'b0;
      else if (evt_i[i]) sts_q[i] <= 1'b1;
      else if (clr_mask[i]) sts_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_wr_i) en_q <= wdata_i;
  end

  assign sts_o = sts_q;
  assign en_o  = en_q;

  // R6
  sts_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sts_wr_i |=> ((sts_q & $past(sts_q)) == $past(sts_q)));
  // R5
  evt_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((sts_q & $past(evt_i)) == $past(evt_i)));
  // R7
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_wr_i |=> $stable(en_q));
endmodule

// File: rtl/pm_evt_irq.sv
module pm_evt_irq
  import pm_evt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [7:0]  cfg_addr_i,
  input  logic [3:0]  cfg_be_i,
  input  logic [31:0] cfg_wdata_i,
  input  logic        io_req_i,
  input  logic        io_we_i,
  input  logic [15:0] io_addr_i,
  input  logic [15:0] io_wdata_i,
  output logic [15:0] io_rdata_o,
  input  logic [15:0] evt_i,
  output logic        irq_o,
  output logic        tmr_arm_o
);
  logic              hit;
  logic [WIN_AW-1:0] off;
  logic [REG_W-1:0]  sts, en;
  logic              wr, sts_wr, en_wr;

  pm_win_decode u_dec (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_be_i, .cfg_wdata_i,
    .io_addr_i, .hit_o(hit), .off_o(off)
  );

  assign wr     = io_req_i && io_we_i && hit;
  assign sts_wr = wr && (off == OFF_STS);
  assign en_wr  = wr && (off == OFF_EN);

  pm_evt_regs u_regs (
    .clk_i, .rst_ni, .evt_i, .sts_wr_i(sts_wr), .en_wr_i(en_wr),
    .wdata_i(io_wdata_i), .sts_o(sts), .en_o(en)
  );

  always_comb begin
    if (!hit)                io_rdata_o = '1;
    else if (off == OFF_STS) io_rdata_o = sts;
    else if (off == OFF_EN)  io_rdata_o = en;
    else                     io_rdata_o = '0;
  end

  assign irq_o     = |(sts & en & IRQ_MASK);
  assign tmr_arm_o = en[BIT_TMR] & ~sts[BIT_TMR];

  // R9
  tmr_disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_wr && !io_wdata_i[BIT_TMR]) |=> !tmr_arm_o);
  // R8
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |(u_regs.sts_o & u_regs.en_o & IRQ_MASK));
endmodule

// File: tb/pm_evt_irq_test.sv
module pm_evt_irq_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic        io_req = 1'b0, io_we = 1'b0;
  logic [15:0] io_addr = '0, io_wdata = '0, io_rdata;
  logic [15:0] evt = '0;
  logic        irq, tmr_arm;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  typedef struct { string tag; int sel; logic [15:0] exp; } item_t;
  item_t sb[$];
  event  mon_ev;

  always #10 clk = ~clk;

  pm_evt_irq uut (
    .clk_i(clk), .rst_ni, .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_be_i(cfg_be), .cfg_wdata_i(cfg_wdata), .io_req_i(io_req),
    .io_we_i(io_we), .io_addr_i(io_addr), .io_wdata_i(io_wdata),
    .io_rdata_o(io_rdata), .evt_i(evt), .irq_o(irq), .tmr_arm_o(tmr_arm)
  );

  // monitor: pops expected items and compares against the selected output
  initial forever begin
    @(mon_ev);
    #1;
    while (sb.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = sb.pop_front();
      act = (it.sel == 0) ? io_rdata : (it.sel == 1) ? {15'd0, irq} : {15'd0, tmr_arm};
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic push(string tag, int sel, logic [15:0] exp);
    item_t it;
    it.tag = tag; it.sel = sel; it.exp = exp;
    sb.push_back(it);
    -> mon_ev;
    #2;
  endtask

  task automatic rd(logic [15:0] a, logic [15:0] exp, string tag);
    @(negedge clk);
    io_req = 1'b1; io_we = 1'b0; io_addr = a;
    push(tag, 0, exp);
    io_req = 1'b0;
  endtask

  task automatic chk_irq(logic e, string tag);
    @(negedge clk);
    push(tag, 1, {15'd0, e});
  endtask

  task automatic chk_tmr(logic e, string tag);
    @(negedge clk);
    push(tag, 2, {15'd0, e});
  endtask

  task automatic wr(logic [15:0] a, logic [15:0] d, logic [15:0] ev = '0);
    @(negedge clk);
    io_req = 1'b1; io_we = 1'b1; io_addr = a; io_wdata = d; evt = ev;
    @(negedge clk);
    io_req = 1'b0; io_we = 1'b0; evt = '0;
  endtask

  task automatic pulse(logic [15:0] ev);
    @(negedge clk);
    evt = ev;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic cfg(logic [7:0] a, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    chk_irq(1'b0, "R1 irq after reset");
    chk_tmr(1'b0, "R1 tmr_arm after reset");
    rd(16'h0000, 16'hFFFF, "R1 window disabled at reset");

    cfg(8'h40, 4'hF, 32'h0000_1234);          // base 0x1200
    rd(16'h1200, 16'hFFFF, "R3 still disabled before enable");
    cfg(8'h80, 4'h1, 32'h0000_0001);
    rd(16'h1200, 16'h0000, "R1 status zero");
    rd(16'h1202, 16'h0000, "R1 enable zero");
    rd(16'h1240, 16'hFFFF, "R4 above window");
    rd(16'h11FE, 16'hFFFF, "R4 below window");

    wr(16'h1202, 16'h0523);
    rd(16'h1202, 16'h0523, "R7 enable readback");
    chk_tmr(1'b1, "R9 armed with en0 and sts0 clear");
    wr(16'h1204, 16'hFFFF);
    rd(16'h1204, 16'h0000, "R7 other offset reads zero");
    rd(16'h1202, 16'h0523, "R7 other offset write ignored");

    pulse(16'h0002);
    rd(16'h1200, 16'h0002, "R5 event sets status");
    chk_irq(1'b0, "R8 unmasked bit no irq");
    pulse(16'h0100);
    rd(16'h1200, 16'h0102, "R5 power button status");
    chk_irq(1'b1, "R8 power button irq");
    wr(16'h1200, 16'h0100);
    rd(16'h1200, 16'h0002, "R6 w1c clears one bit");
    chk_irq(1'b0, "R8 irq drops after clear");

    pulse(16'h0001);
    chk_irq(1'b1, "R8 timer irq");
    chk_tmr(1'b0, "R9 disarmed when timer status set");
    wr(16'h1200, 16'h0000);
    rd(16'h1200, 16'h0003, "R6 writing zero keeps bits");
    wr(16'h1200, 16'h0001, 16'h0001);
    rd(16'h1200, 16'h0003, "R10 set wins over clear");
    wr(16'h1200, 16'hFFFF);
    rd(16'h1200, 16'h0000, "R6 clear all");
    chk_tmr(1'b1, "R9 rearmed");

    pulse(16'h0020);
    chk_irq(1'b1, "R8 global lock irq");
    wr(16'h1200, 16'h0020);
    pulse(16'h0400);
    rd(16'h1200, 16'h0400, "R5 rtc status");
    chk_irq(1'b1, "R8 rtc irq");
    wr(16'h1200, 16'h0400);

    wr(16'h1242, 16'h0000);
    rd(16'h1202, 16'h0523, "R4 outside write ignored");

    cfg(8'h80, 4'h1, 32'h0000_0000);
    rd(16'h1202, 16'hFFFF, "R3 disabled reads ones");
    wr(16'h1202, 16'h0000);
    cfg(8'h80, 4'h1, 32'h0000_0001);
    rd(16'h1202, 16'h0523, "R3 disabled write ignored");

    cfg(8'h40, 4'hF, 32'hABCD_5678);          // base 0x5640
    rd(16'h5642, 16'h0523, "R2 new base masked");
    rd(16'h1202, 16'hFFFF, "R2 old base gone");
    cfg(8'h40, 4'h2, 32'h0000_9900);          // only high byte: base 0x9940
    rd(16'h9942, 16'h0523, "R2 byte lane update");

    done = 1'b1;
    #5;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule